// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a program may touch an I/O port of one, two or four bytes. It receives the port number, the access width, the current privilege level, the I/O privilege level, a virtual-8086 flag and the base and limit of the current task segment. When the privilege rules already permit the access, it answers in the next cycle and reads no memory. Otherwise it looks up a per-task permission bitmap that lives inside the task segment.

The bitmap's 16-bit starting offset is stored at byte 66h of the task segment. The block fetches that offset through a byte-wide memory read port. It then fetches the bitmap byte that holds the port's bit, and the byte after it. Reading two bytes on every lookup lets an access that straddles a byte boundary be checked in one pass. The verdict is a one-cycle `done` pulse carrying either `grant` or `gp_fault`. A lookup whose bytes would fall past the segment limit faults, and so does an unsupported access width.

The memory port has a fixed read latency of one cycle. A byte addressed while `mem_rd_en` is high appears on `mem_rd_data` throughout the following cycle.

Top module: `iopb_check`

## Requirements
- R1: With `req_v86`=0 and `req_cpl` <= `req_iopl`, an accepted request of width 1, 2 or 4 produces `done` with `grant` in the next cycle and issues no memory read.
- R2: With `req_v86`=1, or with `req_cpl` > `req_iopl`, the bitmap is consulted. Its offset is read from `seg_base`+66h (low byte) and `seg_base`+67h (high byte) and combined little-endian.
- R3: The bit for port P is bit P[2:0] of the byte at `seg_base` + offset + (P>>3). A bit value of 1 denies the access and a value of 0 allows it.
- R4: A width-2 access tests the bits of ports P and P+1, and a width-4 access tests the bits of ports P to P+3. The access is granted only when every tested bit is 0.
- R5: Every bitmap lookup reads exactly two bitmap bytes, index and index+1, so 4 reads in total including the offset. An access whose bits span both bytes is judged on both bytes.
- R6: If offset + (P>>3) + 1 exceeds `seg_limit`, the result is `gp_fault`, with `done` 4 cycles after acceptance and no bitmap byte read. An index with index+1 equal to the limit is still looked up.
- R7: A width value other than 1, 2 or 4 yields `done` with `gp_fault` in the next cycle, with no memory read, whatever the privilege inputs.
- R8: Each accepted request produces exactly one `done` pulse, one cycle long, with exactly one of `grant` and `gp_fault` set. A full bitmap lookup completes 7 cycles after acceptance.
- R9: While `busy` is high, `req_valid` is ignored and leaves the pending verdict and its timing unchanged.
- R10: After reset, `done`, `grant`, `gp_fault`, `busy` and `mem_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_port | input | 16 | I/O port number |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level |
| req_v86 | input | 1 | Virtual-8086 mode active |
| seg_base | input | 32 | Task segment base address |
| seg_limit | input | 32 | Task segment limit (last valid byte offset) |
| busy | output | 1 | A lookup is in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 8 | Memory read data, one cycle after the strobe |
| done | output | 1 | Verdict pulse |
| grant | output | 1 | Access allowed (valid with done) |
| gp_fault | output | 1 | Access refused (valid with done) |

## Verification
A verdict is due 1 cycle after acceptance on the privileged and bad-width paths, 4 cycles after acceptance on a limit fault, and 7 cycles after acceptance after a full two-byte lookup. The bench's reference model computes the latency and the verdict for every request and stores the due cycle. On every falling edge it compares `done`: it must be high exactly in the due cycle, with the expected verdict, and low in every other cycle. At the due cycle it also checks the number of memory reads made (0, 2 or 4). This rules out both early and late answers, and any stray pulse caused by a request made while busy.

// File: rtl/iopb_pkg.sv
package iopb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OLO,
        ST_RD_OHI,
        ST_WT_OHI,
        ST_RD_B0,
        ST_RD_B1,
        ST_WT_B1
    } iopb_state_e;

    // Bit mask of bitmap bits covered by an access of the given byte width.
    function automatic logic [3:0] width_mask(input logic [2:0] w);
        case (w)
            3'd1:    width_mask = 4'b0001;
            3'd2:    width_mask = 4'b0011;
            3'd4:    width_mask = 4'b1111;
            default: width_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/iopb_gate.sv
module iopb_gate (
    input  logic [2:0] size,
    input  logic [1:0] cpl,
    input  logic [1:0] iopl,
    input  logic       v86,
    output logic       size_ok,
    output logic       need_map,
    output logic [3:0] mask
);
    import iopb_pkg::*;

    always_comb begin
        mask     = width_mask(size);
        size_ok  = (mask != 4'b0000);
        need_map = v86 || (cpl > iopl);
    end
endmodule

// File: rtl/iopb_window.sv
module iopb_window #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 32,
    parameter int SH_W   = 13,
    localparam int IDX_W = ((SH_W > 16) ? SH_W : 16) + 1,
    localparam int CW    = ((IDX_W + 1) > LIM_W) ? (IDX_W + 1) : LIM_W
) (
    input  logic [15:0]       map_off,
    input  logic [SH_W-1:0]   port_hi,
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    output logic [ADDR_W-1:0] addr0,
    output logic [ADDR_W-1:0] addr1,
    output logic              in_range
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx      = IDX_W'(map_off) + IDX_W'(port_hi);
        in_range = (CW'(idx) + CW'(1)) <= CW'(limit);
        addr0    = base + ADDR_W'(idx);
        addr1    = addr0 + ADDR_W'(1);
    end
endmodule

// File: rtl/iopb_bits_eval.sv
module iopb_bits_eval (
    input  logic [7:0] lo_byte,
    input  logic [7:0] hi_byte,
    input  logic [2:0] bit_sel,
    input  logic [3:0] mask,
    output logic       all_clear
);
    logic [15:0] window;

    always_comb begin
        window    = {hi_byte, lo_byte} >> bit_sel;
        all_clear = ((window[3:0] & mask) == 4'b0000);
    end
endmodule

// File: rtl/iopb_check.sv
module iopb_check #(
    parameter int ADDR_W    = 32,
    parameter int LIM_W     = 32,
    parameter int PORT_W    = 16,
    parameter int MAP_PTR   = 'h66,
    localparam int SH_W     = PORT_W - 3,
    localparam int IDX_W    = ((SH_W > 16) ? SH_W : 16) + 1,
    localparam int CW       = ((IDX_W + 1) > LIM_W) ? (IDX_W + 1) : LIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_iopl,
    input  logic              req_v86,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LIM_W-1:0]  seg_limit,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              done,
    output logic              grant,
    output logic              gp_fault
);
    import iopb_pkg::*;

    typedef struct packed {
        iopb_state_e       state;
        logic [PORT_W-1:0] port;
        logic [3:0]        mask;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [7:0]        off_lo;
        logic [7:0]        b0;
        logic [ADDR_W-1:0] nxt;
        logic              rd_en;
        logic [ADDR_W-1:0] rd_addr;
        logic              done;
        logic              grant;
        logic              fault;
    } iopb_regs_t;

    iopb_regs_t r_d, r_q;

    logic              size_ok, need_map;
    logic [3:0]        mask_in;
    logic [ADDR_W-1:0] win_a0, win_a1;
    logic              win_ok;
    logic              bits_clear;

    iopb_gate u_gate (
        .size     (req_size),
        .cpl      (req_cpl),
        .iopl     (req_iopl),
        .v86      (req_v86),
        .size_ok  (size_ok),
        .need_map (need_map),
        .mask     (mask_in)
    );

    iopb_window #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SH_W(SH_W)) u_window (
        .map_off  ({mem_rd_data, r_q.off_lo}),
        .port_hi  (r_q.port[PORT_W-1:3]),
        .base     (r_q.base),
        .limit    (r_q.limit),
        .addr0    (win_a0),
        .addr1    (win_a1),
        .in_range (win_ok)
    );

    iopb_bits_eval u_bits (
        .lo_byte   (r_q.b0),
        .hi_byte   (mem_rd_data),
        .bit_sel   (r_q.port[2:0]),
        .mask      (r_q.mask),
        .all_clear (bits_clear)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rd_en = 1'b0;
        r_d.done  = 1'b0;
        r_d.grant = 1'b0;
        r_d.fault = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.port  = req_port;
                    r_d.mask  = mask_in;
                    r_d.base  = seg_base;
                    r_d.limit = seg_limit;
                    if (!size_ok) begin
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b1;
                    end else if (!need_map) begin
                        r_d.done  = 1'b1;
                        r_d.grant = 1'b1;
                    end else begin
                        r_d.rd_en   = 1'b1;
                        r_d.rd_addr = seg_base + ADDR_W'(MAP_PTR);
                        r_d.state   = ST_RD_OLO;
                    end
                end
            end
            ST_RD_OLO: begin
                r_d.rd_en   = 1'b1;
                r_d.rd_addr = r_q.base + ADDR_W'(MAP_PTR + 1);
                r_d.state   = ST_RD_OHI;
            end
            ST_RD_OHI: begin
                r_d.off_lo = mem_rd_data;
                r_d.state  = ST_WT_OHI;
            end
            ST_WT_OHI: begin
                if (!win_ok) begin
                    r_d.done  = 1'b1;
                    r_d.fault = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.rd_en   = 1'b1;
                    r_d.rd_addr = win_a0;
                    r_d.nxt     = win_a1;
                    r_d.state   = ST_RD_B0;
                end
            end
            ST_RD_B0: begin
                r_d.rd_en   = 1'b1;
                r_d.rd_addr = r_q.nxt;
                r_d.state   = ST_RD_B1;
            end
            ST_RD_B1: begin
                r_d.b0    = mem_rd_data;
                r_d.state = ST_WT_B1;
            end
            ST_WT_B1: begin
                r_d.done  = 1'b1;
                r_d.grant = bits_clear;
                r_d.fault = !bits_clear;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign mem_rd_en   = r_q.rd_en;
    assign mem_rd_addr = r_q.rd_addr;
    assign done        = r_q.done;
    assign grant       = r_q.grant;
    assign gp_fault    = r_q.fault;

    // R1: privileged path answers next cycle with a grant and no read
    a_r1_fast_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !req_v86 && (req_cpl <= req_iopl) &&
         (req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
        |=> (done && grant && !mem_rd_en));

    // R7: unsupported width faults next cycle without touching memory
    a_r7_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid &&
         !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
        |=> (done && gp_fault && !mem_rd_en));

    // R6: no bitmap byte is fetched beyond the segment limit
    a_r6_read_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && (r_q.state == ST_RD_B0 || r_q.state == ST_RD_B1))
        |-> (CW'(mem_rd_addr - r_q.base) <= CW'(r_q.limit)));

    // R8: a verdict carries exactly one of grant and fault
    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({grant, gp_fault}));

    a_r8_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(grant || gp_fault));

    // R5: the second bitmap byte follows the first one directly
    a_r5_adjacent_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && r_q.state == ST_RD_B1)
        |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1)));

endmodule

// File: tb/iopb_check_tb.sv
module iopb_check_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_port = '0;
    logic [2:0]  req_size = 3'd1;
    logic [1:0]  req_cpl = '0;
    logic [1:0]  req_iopl = '0;
    logic        req_v86 = 1'b0;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = '0;
    logic        busy, mem_rd_en, done, grant, gp_fault;
    logic [31:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int due = -1;
    int rd_count = 0;
    bit pending = 0;
    bit exp_grant = 0;
    int exp_reads = 0;
    string cur_tag = "";

    logic [7:0] mem [int unsigned];

    always #5 clk = ~clk;

    iopb_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_cpl(req_cpl), .req_iopl(req_iopl),
        .req_v86(req_v86), .seg_base(seg_base), .seg_limit(seg_limit),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .done(done), .grant(grant), .gp_fault(gp_fault)
    );

    function automatic logic [7:0] rd_byte(input int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) begin
            mem_rd_data <= rd_byte(mem_rd_addr);
            rd_count    <= rd_count + 1;
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (pending && cyc == due) begin
                if (!(done && grant == exp_grant && gp_fault == !exp_grant)) begin
                    n_err++;
                    $display("FAIL %s: done=%0b grant=%0b fault=%0b expected done=1 grant=%0b",
                             cur_tag, done, grant, gp_fault, exp_grant);
                end
                n_chk++;
                if (rd_count != exp_reads) begin
                    n_err++;
                    $display("FAIL %s reads: got %0d expected %0d", cur_tag, rd_count, exp_reads);
                end
                pending = 0;
            end else if (done) begin
                n_err++;
                $display("FAIL R8/R9 stray done at cycle %0d: got 1 expected 0", cyc);
            end
        end
    end

    // Behavioural model: verdict, latency and read count of one request.
    task automatic model(input int port, input int size, input int cpl, input int iopl,
                         input bit v86, input int unsigned base, input int unsigned limit,
                         output bit g, output int lat, output int nrd);
        int unsigned off, idx, w, bits;
        if (size != 1 && size != 2 && size != 4) begin
            g = 0; lat = 1; nrd = 0;
        end else if (!v86 && cpl <= iopl) begin
            g = 1; lat = 1; nrd = 0;
        end else begin
            off = rd_byte(base + 'h66) | (rd_byte(base + 'h67) << 8);
            idx = off + (port >> 3);
            if (idx + 1 > limit) begin
                g = 0; lat = 4; nrd = 2;
            end else begin
                w    = rd_byte(base + idx) | (rd_byte(base + idx + 1) << 8);
                bits = (w >> (port % 8)) & ((1 << size) - 1);
                g = (bits == 0); lat = 7; nrd = 4;
            end
        end
    endtask

    task automatic run(input string tag, input int port, input int size, input int cpl,
                       input int iopl, input bit v86, input int unsigned base,
                       input int unsigned limit, input bit poke);
        bit g; int lat, nrd;
        model(port, size, cpl, iopl, v86, base, limit, g, lat, nrd);
        @(negedge clk);
        req_valid = 1'b1; req_port = port[15:0]; req_size = size[2:0];
        req_cpl = cpl[1:0]; req_iopl = iopl[1:0]; req_v86 = v86;
        seg_base = base; seg_limit = limit;
        rd_count = 0;
        cur_tag = tag; exp_grant = g; exp_reads = nrd;
        due = cyc + lat; pending = 1;
        @(negedge clk);
        if (poke && lat > 2) begin
            // R9: a request made while busy must not be taken
            req_valid = 1'b1; req_size = 3'd3; req_v86 = 1'b0; req_cpl = 2'd0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (cyc <= due) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int unsigned b;
        b = 32'h0000_1000;
        mem[b + 'h66] = 8'h68;
        mem[b + 'h67] = 8'h00;
        for (int i = 0; i < 16; i++) mem[b + 'h68 + i] = 8'hFF;
        mem[b + 'h68 + 8]  = 8'h0F;   // ports 40h-43h denied, 44h-47h allowed
        mem[b + 'h68 + 9]  = 8'h00;   // ports 48h-4Fh allowed
        mem[b + 'h68 + 10] = 8'h01;   // port 50h denied, 51h-57h allowed

        repeat (3) @(negedge clk);
        // R10: reset values
        n_chk++;
        if (done || grant || gp_fault || busy || mem_rd_en) begin
            n_err++;
            $display("FAIL R10: done=%0b grant=%0b fault=%0b busy=%0b rd=%0b expected all 0",
                     done, grant, gp_fault, busy, mem_rd_en);
        end
        rst_n = 1'b1;
        @(negedge clk);

        run("R1 privileged grant on denied port", 'h40, 1, 0, 0, 0, b, 'hFFFF, 0);
        run("R1 equal cpl iopl", 'h40, 4, 3, 3, 0, b, 'hFFFF, 0);
        run("R7 width 3", 'h44, 3, 0, 0, 0, b, 'hFFFF, 0);
        run("R7 width 0 with bitmap", 'h44, 0, 3, 0, 1, b, 'hFFFF, 0);
        run("R2 v86 denied byte", 'h40, 1, 0, 0, 1, b, 'hFFFF, 0);
        run("R2 cpl above iopl allowed", 'h44, 1, 3, 2, 0, b, 'hFFFF, 0);
        run("R3 bit 3 denied", 'h43, 1, 3, 0, 0, b, 'hFFFF, 0);
        run("R4 dword allowed", 'h44, 4, 3, 0, 0, b, 'hFFFF, 0);
        run("R4 word straddles denied bit", 'h43, 2, 3, 0, 0, b, 'hFFFF, 0);
        run("R5 word across bytes allowed", 'h47, 2, 3, 0, 0, b, 'hFFFF, 0);
        run("R5 dword across bytes denied", 'h4E, 4, 3, 0, 0, b, 'hFFFF, 0);
        run("R6 last byte in limit", 'h40, 1, 3, 0, 1, b, 'h71, 0);
        run("R6 past limit", 'h48, 1, 3, 0, 1, b, 'h71, 0);
        run("R6 far port past limit", 'hFFF8, 1, 3, 0, 1, b, 'h1000, 0);
        run("R9 poke during lookup", 'h44, 2, 3, 0, 0, b, 'hFFFF, 1);
        run("R9 poke during limit fault", 'h48, 1, 3, 0, 1, b, 'h71, 1);
        for (int p = 'h38; p < 'h58; p++) begin
            run("R3/R4/R5 sweep w1", p, 1, 2, 1, 0, b, 'hFFFF, 0);
            run("R3/R4/R5 sweep w2", p, 2, 0, 0, 1, b, 'hFFFF, 0);
            run("R3/R4/R5 sweep w4", p, 4, 3, 0, 0, b, 'hFFFF, 0);
        end

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule